// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Timer

This block is the timing engine of a master for a half-duplex, open-drain bus made of one shared data line that an external resistor pulls high. It drives the line low only through an enable output and reads the line through an input that it synchronizes itself. Four commands come from the host: an initialization sequence, a write-0 slot, a write-1 slot and a read slot. Each command begins with the master pulling the idle line low. The bit's meaning lies in how long the line stays low compared with a fixed sampling instant. Every slot is followed by a recovery gap during which the line is released.

The host offers a command with a valid/ready handshake. Ready drops for the whole sequence. A one-clock done strobe marks the end of the recovery gap. At that point the result output holds the presence flag after an initialization, or the sampled bit after a read. All durations are parameters in microseconds. A prescaler turns the clock into a microsecond tick, and the tick is re-phased when each command is accepted, so every duration is an exact multiple of the clock.

Top module: `owbMaster`

## Requirements
- R1: After reset, cmdReady is 1, busDriveLow is 0 and done is 0.
- R2: While a command runs, cmdReady is 0 and any cmdValid is ignored. The running command keeps its timing and result, and a new command is accepted only once cmdReady is 1 again.
- R3: Command code 0 (initialize) drives the line low for exactly RST_LOW_US microseconds. The low starts one clock after acceptance. The line is then released for RST_HIGH_US microseconds.
- R4: For code 0, the line is sampled PRES_SAMPLE_US microseconds after release. resultBit becomes 1 if the line was low (device present) and 0 if it was high.
- R5: Command code 2 (write 1) drives low for SHORT_LOW_US microseconds and then releases the line for the rest of a SLOT_US slot.
- R6: Command code 1 (write 0) drives low for the full SLOT_US slot.
- R7: Command code 3 (read) drives low for SHORT_LOW_US microseconds and releases the line. It samples the line READ_SAMPLE_US microseconds after the slot start, and resultBit equals the sampled line level.
- R8: After each slot window, the line stays released for REC_US microseconds. Then done pulses for exactly one clock, (window + REC_US) × CLK_PER_US clocks after acceptance, and cmdReady returns to 1 in that same cycle.
- R9: Write commands (codes 1 and 2) leave resultBit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Host offers a command |
| cmdCode | input | 2 | 0 initialize, 1 write 0, 2 write 1, 3 read |
| cmdReady | output | 1 | Engine idle and able to accept |
| done | output | 1 | One-clock end-of-command strobe |
| resultBit | output | 1 | Presence flag or read bit, valid with done |
| busDriveLow | output | 1 | Enable of the open-drain pull-down |
| busLineIn | input | 1 | Raw level of the bus line |

## Verification
A wrong phase or microsecond count shows directly at busDriveLow: the low pulse is too long, too short or misplaced by whole microseconds, and this is visible within the same slot. A wrong sampling instant or polarity shows as a wrong resultBit at the done strobe of that command. This is exposed by the device model, which holds the line low only around the expected sample point. A stuck phase or broken handshake shows as done arriving at the wrong clock, or as cmdReady rising early so that a held-off command slips in.

// File: rtl/owbPkg.sv
package owbPkg;

  typedef enum logic [1:0] {
    CMD_INIT   = 2'd0,
    CMD_WRITE0 = 2'd1,
    CMD_WRITE1 = 2'd2,
    CMD_READ   = 2'd3
  } owbCmd_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SLOT  = 2'd1,
    PH_RECOV = 2'd2
  } owbPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;      // re-phase prescaler and zero the microsecond count
    logic restartCount;  // zero the microsecond count at a phase change
    logic driveLow;      // next value of the pull-down enable
    logic capture;       // latch the synchronized line into the result
    logic presenceMode;  // capture inverts: low line means present
  } ctlStrobe_t;

endpackage

// File: rtl/owbDatapath.sv
module owbDatapath
  import owbPkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int US_W       = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      strobe,
  input  logic            busLineIn,
  output logic            tick,
  output logic [US_W-1:0] usCount,
  output logic            resultBit,
  output logic            busDriveLow
);

  localparam int PRE_W = $clog2(CLK_PER_US + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

  logic [PRE_W-1:0] preCount;
  logic [1:0]       lineSync;
  logic             resultQ;
  logic             driveQ;

  assign tick = (preCount == PRE_LAST);

  // microsecond prescaler and phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCount <= '0;
      usCount  <= '0;
    end else if (strobe.clearAll) begin
      preCount <= '0;
      usCount  <= '0;
    end else begin
      preCount <= tick ? '0 : preCount + 1'b1;
      if (strobe.restartCount)
        usCount <= '0;
      else if (tick)
        usCount <= usCount + 1'b1;
    end
  end

  // two-flop synchronizer; the idle line is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineSync <= 2'b11;
    else       lineSync <= {lineSync[0], busLineIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= 1'b0;
      driveQ  <= 1'b0;
    end else begin
      driveQ <= strobe.driveLow;
      if (strobe.capture)
        resultQ <= strobe.presenceMode ? ~lineSync[1] : lineSync[1];
    end
  end

  assign resultBit   = resultQ;
  assign busDriveLow = driveQ;

endmodule

// File: rtl/owbControl.sv
module owbControl
  import owbPkg::*;
#(
  parameter int RST_LOW_US     = 480,
  parameter int PRES_SAMPLE_US = 70,
  parameter int RST_HIGH_US    = 480,
  parameter int SLOT_US        = 70,
  parameter int SHORT_LOW_US   = 6,
  parameter int READ_SAMPLE_US = 12,
  parameter int REC_US         = 2,
  parameter int US_W           = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [1:0]      cmdCode,
  input  logic            tick,
  input  logic [US_W-1:0] usCount,
  output logic            cmdReady,
  output logic            done,
  output ctlStrobe_t      strobe
);

  localparam logic [US_W-1:0] INIT_LOW   = US_W'(RST_LOW_US);
  localparam logic [US_W-1:0] INIT_SAMP  = US_W'(RST_LOW_US + PRES_SAMPLE_US - 1);
  localparam logic [US_W-1:0] INIT_LAST  = US_W'(RST_LOW_US + RST_HIGH_US - 1);
  localparam logic [US_W-1:0] SLOT_LAST  = US_W'(SLOT_US - 1);
  localparam logic [US_W-1:0] SLOT_FULL  = US_W'(SLOT_US);
  localparam logic [US_W-1:0] SHORT_LOW  = US_W'(SHORT_LOW_US);
  localparam logic [US_W-1:0] READ_SAMP  = US_W'(READ_SAMPLE_US - 1);
  localparam logic [US_W-1:0] REC_LAST   = US_W'(REC_US - 1);

  owbPhase_t phase, phaseNext;
  owbCmd_t   cmdQ;
  logic      doneQ, finish;

  logic [US_W-1:0] lowLen, sampLast, winLast;
  logic            sampleEn;

  // per-command slot shape
  always_comb begin
    unique case (cmdQ)
      CMD_INIT: begin
        lowLen = INIT_LOW;  sampLast = INIT_SAMP; winLast = INIT_LAST; sampleEn = 1'b1;
      end
      CMD_WRITE0: begin
        lowLen = SLOT_FULL; sampLast = '0;        winLast = SLOT_LAST; sampleEn = 1'b0;
      end
      CMD_WRITE1: begin
        lowLen = SHORT_LOW; sampLast = '0;        winLast = SLOT_LAST; sampleEn = 1'b0;
      end
      default: begin
        lowLen = SHORT_LOW; sampLast = READ_SAMP; winLast = SLOT_LAST; sampleEn = 1'b1;
      end
    endcase
  end

  always_comb begin
    strobe    = '0;
    phaseNext = phase;
    finish    = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (cmdValid) begin
          strobe.clearAll = 1'b1;
          phaseNext       = PH_SLOT;
        end
      end
      PH_SLOT: begin
        strobe.driveLow     = (usCount < lowLen);
        strobe.capture      = sampleEn && tick && (usCount == sampLast);
        strobe.presenceMode = (cmdQ == CMD_INIT);
        if (tick && usCount == winLast) begin
          strobe.restartCount = 1'b1;
          phaseNext           = PH_RECOV;
        end
      end
      PH_RECOV: begin
        if (tick && usCount == REC_LAST) begin
          finish    = 1'b1;
          phaseNext = PH_IDLE;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cmdQ  <= CMD_INIT;
      doneQ <= 1'b0;
    end else begin
      phase <= phaseNext;
      doneQ <= finish;
      if (phase == PH_IDLE && cmdValid)
        cmdQ <= owbCmd_t'(cmdCode);
    end
  end

  assign cmdReady = (phase == PH_IDLE);
  assign done     = doneQ;

endmodule

// File: rtl/owbMaster.sv
module owbMaster
  import owbPkg::*;
#(
  parameter int CLK_PER_US     = 50,
  parameter int RST_LOW_US     = 480,
  parameter int PRES_SAMPLE_US = 70,
  parameter int RST_HIGH_US    = 480,
  parameter int SLOT_US        = 70,
  parameter int SHORT_LOW_US   = 6,
  parameter int READ_SAMPLE_US = 12,
  parameter int REC_US         = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdCode,
  output logic       cmdReady,
  output logic       done,
  output logic       resultBit,
  output logic       busDriveLow,
  input  logic       busLineIn
);

  localparam int INIT_SPAN = RST_LOW_US + RST_HIGH_US;
  localparam int SPAN_A    = (INIT_SPAN > SLOT_US) ? INIT_SPAN : SLOT_US;
  localparam int SPAN      = (SPAN_A > REC_US) ? SPAN_A : REC_US;
  localparam int US_W      = $clog2(SPAN + 1);

  ctlStrobe_t      strobe;
  logic            tick;
  logic [US_W-1:0] usCount;

  owbControl #(
    .RST_LOW_US(RST_LOW_US), .PRES_SAMPLE_US(PRES_SAMPLE_US),
    .RST_HIGH_US(RST_HIGH_US), .SLOT_US(SLOT_US),
    .SHORT_LOW_US(SHORT_LOW_US), .READ_SAMPLE_US(READ_SAMPLE_US),
    .REC_US(REC_US), .US_W(US_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .tick(tick), .usCount(usCount), .cmdReady(cmdReady), .done(done),
    .strobe(strobe)
  );

  owbDatapath #(
    .CLK_PER_US(CLK_PER_US), .US_W(US_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busLineIn(busLineIn),
    .tick(tick), .usCount(usCount), .resultBit(resultBit),
    .busDriveLow(busDriveLow)
  );

endmodule

// File: rtl/owbMasterChecker.sv
module owbMasterChecker (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [1:0] cmdCode,
  input logic       cmdReady,
  input logic       done,
  input logic       resultBit,
  input logic       busDriveLow,
  input logic       busLineIn
);

  // R1 / R8: an idle engine never pulls the line
  assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !busDriveLow);

  // R8: done is a single-clock strobe
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: done coincides with the return to idle
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> cmdReady);

  // R2: ready only drops because a command was offered
  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdReady) |-> $past(cmdValid));

  // R2: a low pulse only begins inside an accepted command
  assert_drive_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busDriveLow) |-> $past(!cmdReady));

  // R9: the result never moves while idle
  assert_result_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReady && !cmdValid) |=> $stable(resultBit));

  // the line input is always a known level
  assert_line_known_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown({busLineIn, cmdCode}));

endmodule

bind owbMaster owbMasterChecker u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
  .cmdReady(cmdReady), .done(done), .resultBit(resultBit),
  .busDriveLow(busDriveLow), .busLineIn(busLineIn)
);

// File: tb/owbMaster_test.sv
module owbMaster_test;

  localparam int CLK_PERIOD = 10;
  localparam int P     = 3;
  localparam int RLOW  = 20;
  localparam int PSAMP = 7;
  localparam int RHIGH = 24;
  localparam int SLOT  = 14;
  localparam int SHORT = 2;
  localparam int RSAMP = 4;
  localparam int REC   = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdCode = 2'd0;
  logic       cmdReady, done, resultBit, busDriveLow;
  logic       devLow = 1'b0;
  logic       busLineIn;

  int testsRun = 0;
  int testsFailed = 0;
  bit expResult = 1'b0;

  assign busLineIn = ~(busDriveLow | devLow);

  always #(CLK_PERIOD/2) clk = ~clk;

  owbMaster #(
    .CLK_PER_US(P), .RST_LOW_US(RLOW), .PRES_SAMPLE_US(PSAMP),
    .RST_HIGH_US(RHIGH), .SLOT_US(SLOT), .SHORT_LOW_US(SHORT),
    .READ_SAMPLE_US(RSAMP), .REC_US(REC)
  ) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdReady(cmdReady), .done(done), .resultBit(resultBit),
    .busDriveLow(busDriveLow), .busLineIn(busLineIn)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one command with a device model; junk holds cmdValid high while busy
  task automatic runCmd(input int code, input bit devVal, input bit junk);
    int lowLen, win, doneExp, lowCnt, firstLow, lastLow, doneIdx, doneCnt, readyBad;
    string req;
    lowCnt = 0; firstLow = -1; lastLow = -1; doneIdx = -1; doneCnt = 0; readyBad = 0;
    case (code)
      0: begin lowLen = RLOW;  win = RLOW + RHIGH; req = "R3"; end
      1: begin lowLen = SLOT;  win = SLOT;         req = "R6"; end
      2: begin lowLen = SHORT; win = SLOT;         req = "R5"; end
      default: begin lowLen = SHORT; win = SLOT;   req = "R7"; end
    endcase
    doneExp = (win + REC) * P;
    @(negedge clk);
    cmdValid = 1'b1;
    cmdCode  = 2'(code);
    devLow   = 1'b0;
    @(posedge clk);
    for (int k = 0; k <= doneExp; k++) begin
      @(negedge clk);
      if (busDriveLow) begin
        lowCnt++;
        if (firstLow < 0) firstLow = k;
        lastLow = k;
      end
      if (done) begin doneCnt++; if (doneIdx < 0) doneIdx = k; end
      if (k < doneExp && cmdReady) readyBad++;
      if (k == doneExp && !cmdReady) readyBad++;
      cmdValid = junk && (k < doneExp - 1);
      cmdCode  = 2'((code + 1) % 4);
      if (code == 0)
        devLow = devVal && (k >= P*(RLOW+2)) && (k < P*(RLOW+12));
      else if (code == 3)
        devLow = !devVal && (k >= P) && (k < P*8);
      else
        devLow = 1'b0;
    end
    devLow = 1'b0;
    check(req, "low clocks", lowCnt, lowLen * P);
    check(req, "first low clock", firstLow, 1);
    check("R8", "last low clock", lastLow, lowLen * P);
    check("R8", "done clock", doneIdx, doneExp);
    check("R8", "done count", doneCnt, 1);
    check("R2", "ready while busy", readyBad, 0);
    if (code == 0) expResult = devVal;        // R4 presence
    else if (code == 3) expResult = devVal;   // R7 read level
    check(code == 0 ? "R4" : (code == 3 ? "R7" : "R9"), "resultBit",
          int'(resultBit), int'(expResult));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "ready after reset", int'(cmdReady), 1);
    check("R1", "drive after reset", int'(busDriveLow), 0);
    check("R1", "done after reset", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "result after reset", int'(resultBit), 0);
    // sweep: junk outer so writes see both prior results
    for (int j = 0; j < 2; j++)
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 4; c++)
          runCmd(c, d[0], j[0]);
    // back-to-back: presence then read 0 then write (R9 keeps 0)
    runCmd(0, 1'b1, 1'b0);
    runCmd(3, 1'b0, 1'b0);
    runCmd(2, 1'b0, 1'b1);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule